// File: doc/BRIEF.md
# Masked Multi-Width Lane Issue Sequencer

This block takes one instruction shared by up to four threads and spreads its execution over a datapath of four 64-bit lanes (256 bits in all). A 4-bit thread mask says which threads take part. A 2-bit class says how wide the operation is: a 64-bit scalar, a 128-bit packed operation, a 256-bit full vector, or a divide that cannot be pipelined. Each cycle the block reports which threads issue and, for every lane, which thread and which 64-bit register slice that lane serves. The block stays busy until every thread in the mask has been served.

Register slices are interleaved across lanes by thread index. Thread t keeps slice s in lane t XOR s. Because of this, a scalar operation reaches every thread in one cycle. A 128-bit operation can pair two threads whose indices differ by two. A full-width operation occupies all four lanes for one thread. Memory accesses of the instruction are sequenced by the same rules and the same outputs.

Top module: `lane_issue_seq`

## Requirements
- R1: In an issue cycle, each lane j that is used reports thread t in field `lane_thread[2j+1:2j]` and slice t XOR j in field `lane_slice[2j+1:2j]`, with `lane_en[j]` high. Lane j is used when issued thread t has (t XOR j) below the slice count of the class: 1 for classes 0 and 3, 2 for class 1, 4 for class 2. Unused lanes report all zeros.
- R2: Class codes are: 0 = 64-bit scalar, 1 = 128-bit packed, 2 = 256-bit full, 3 = divide. A start is taken only at a clock edge where `busy` is low. The first issue appears in the cycle after that edge, and `busy` is high from that cycle until the work is done. After reset `busy`, `issue_valid` and all lane outputs are low.
- R3: A scalar instruction issues all its masked threads in one cycle. `busy` is low in the cycle after that issue.
- R4: A packed instruction issues, each cycle, the lowest remaining thread t together with thread t XOR 2 if that thread is still pending. Mask 4'b0111 issues {0,2} and then {1}. Mask 4'b0011 issues {0} and then {1}.
- R5: A full-width instruction issues one masked thread per cycle, in back-to-back cycles, in ascending thread order.
- R6: A divide issues one thread at a time, in ascending order. The next issue comes DIV_LAT cycles after the previous one. `busy` falls DIV_LAT cycles after the last divide issue.
- R7: Threads whose mask bit is clear never issue and take no cycle. An all-zero mask produces no issue and no busy cycle, for every class.
- R8: A start presented while `busy` is high is ignored. The sequence in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Present a new instruction |
| mask_in | input | 4 | Threads taking part, bit t for thread t |
| op_in | input | 2 | Operation class code |
| busy | output | 1 | Instruction still being served |
| issue_valid | output | 1 | Threads issue this cycle |
| issue_threads | output | 4 | Threads issued this cycle |
| lane_en | output | 4 | Lanes in use this cycle |
| lane_thread | output | 8 | Thread served by each lane, 2 bits per lane |
| lane_slice | output | 8 | Register slice served by each lane, 2 bits per lane |

## Verification
The bench builds the block with DIV_LAT set to 3 instead of the default 4. Divides then leave two idle busy cycles between issues, so the spacing rule and the falling edge of busy after the last divide are both checked. The reference model generates each instruction's expected per-cycle issue list, including those idle divide cycles, straight from the class rules. The stimulus covers packed masks that pair, split or leave a partner missing, as well as starts made while busy and a start made in the cycle busy falls.

// File: rtl/lane_issue_seq.sv
module lane_issue_seq #(
  parameter int DIV_LAT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] mask_in,
  input  logic [1:0] op_in,
  output logic       busy,
  output logic       issue_valid,
  output logic [3:0] issue_threads,
  output logic [3:0] lane_en,
  output logic [7:0] lane_thread,
  output logic [7:0] lane_slice
);
  localparam logic [1:0] OP_S64  = 2'd0;
  localparam logic [1:0] OP_P128 = 2'd1;
  localparam logic [1:0] OP_F256 = 2'd2;
  localparam logic [1:0] OP_DIV  = 2'd3;
  localparam int CW = (DIV_LAT > 1) ? $clog2(DIV_LAT) : 1;

  logic [3:0]    rem;
  logic [1:0]    op_q;
  logic [CW-1:0] wait_q;
  logic [3:0]    low, pick;
  logic [2:0]    nsl;

  assign low = rem & (~rem + 4'd1);

  always_comb begin
    case (op_q)
      OP_S64:  pick = rem;
      OP_P128: pick = rem & (low | {low[1:0], low[3:2]});
      default: pick = low;
    endcase
  end

  assign issue_valid   = (rem != 4'd0) && (wait_q == '0);
  assign issue_threads = issue_valid ? pick : 4'd0;
  assign busy          = (rem != 4'd0) || (wait_q != '0);
  assign nsl           = (op_q == OP_P128) ? 3'd2 : (op_q == OP_F256) ? 3'd4 : 3'd1;

  always_comb begin
    lane_en     = 4'd0;
    lane_thread = 8'd0;
    lane_slice  = 8'd0;
    for (int j = 0; j < 4; j++) begin
      for (int t = 0; t < 4; t++) begin
        if (issue_threads[t] && ({1'b0, 2'(t ^ j)} < nsl)) begin
          lane_en[j]         = 1'b1;
          lane_thread[2*j+:2] = 2'(t);
          lane_slice[2*j+:2]  = 2'(t ^ j);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem    <= 4'd0;
      op_q   <= OP_S64;
      wait_q <= '0;
    end else if (start && !busy) begin
      rem  <= mask_in;
      op_q <= op_in;
    end else if (issue_valid) begin
      rem <= rem & ~pick;
      if (op_q == OP_DIV) wait_q <= CW'(DIV_LAT - 1);
    end else if (wait_q != '0) begin
      wait_q <= wait_q - 1'b1;
    end
  end

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (mask_in != 4'd0) |=> busy);
  a_r7_zero_mask_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && (mask_in == 4'd0) |=> !busy && !issue_valid);
  a_r3_scalar_done: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && (op_q == OP_S64) |=> !busy);
  a_r4_pack_pair: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && (op_q == OP_P128) |->
      ($countones(issue_threads) == 1) || (issue_threads == 4'b0101) || (issue_threads == 4'b1010));
  a_r5_full_single: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid && (op_q == OP_F256) |-> $countones(issue_threads) == 1);
  a_r6_div_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (DIV_LAT > 1) && issue_valid && (op_q == OP_DIV) |=> !issue_valid);
  a_r8_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !issue_valid |=> $stable(op_q));
  a_r1_lane_unique: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> lane_en != 4'd0);
endmodule

// File: tb/lane_issue_seq_bench.sv
`timescale 1ns/1ps
module lane_issue_seq_bench;
  localparam int DLAT = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] mask_in = 4'd0;
  logic [1:0] op_in = 2'd0;
  logic       busy, issue_valid;
  logic [3:0] issue_threads, lane_en;
  logic [7:0] lane_thread, lane_slice;

  int errors = 0;
  int checks = 0;
  logic [6:0] q[$];

  lane_issue_seq #(.DIV_LAT(DLAT)) u_lane_issue_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .mask_in(mask_in), .op_in(op_in),
    .busy(busy), .issue_valid(issue_valid), .issue_threads(issue_threads),
    .lane_en(lane_en), .lane_thread(lane_thread), .lane_slice(lane_slice));

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input string what, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [19:0] lanes_of(input logic [3:0] thr, input logic [1:0] op);
    logic [3:0] en = 4'd0;
    logic [7:0] th = 8'd0, sl = 8'd0;
    int ns = (op == 2'd1) ? 2 : (op == 2'd2) ? 4 : 1;
    for (int t = 0; t < 4; t++)
      if (thr[t])
        for (int s = 0; s < ns; s++) begin
          en[t ^ s]         = 1'b1;
          th[2*(t ^ s)+:2]  = 2'(t);
          sl[2*(t ^ s)+:2]  = 2'(s);
        end
    return {en, th, sl};
  endfunction

  task automatic build(input logic [3:0] m, input logic [1:0] o);
    logic [3:0] rest = m;
    logic [3:0] g;
    int lo;
    case (o)
      2'd0: if (m != 4'd0) q.push_back({o, 1'b1, m});
      2'd1: while (rest != 4'd0) begin
              lo = 0;
              for (int t = 3; t >= 0; t--) if (rest[t]) lo = t;
              g = rest & ((4'd1 << lo) | (4'd1 << (lo ^ 2)));
              q.push_back({o, 1'b1, g});
              rest = rest & ~g;
            end
      2'd2: for (int t = 0; t < 4; t++) if (m[t]) q.push_back({o, 1'b1, 4'(1 << t)});
      default: for (int t = 0; t < 4; t++) if (m[t]) begin
                 q.push_back({o, 1'b1, 4'(1 << t)});
                 for (int k = 1; k < DLAT; k++) q.push_back({o, 1'b0, 4'd0});
               end
    endcase
  endtask

  task automatic step(input logic s, input logic [3:0] m, input logic [1:0] o, input string tag);
    logic [6:0] e;
    logic eb;
    @(negedge clk);
    eb = (q.size() > 0);
    e  = eb ? q[0] : 7'd0;
    check(tag, "busy", 20'(busy), 20'(eb));
    check(tag, "issue_valid", 20'(issue_valid), 20'(e[4]));
    check(tag, "issue_threads", 20'(issue_threads), 20'(e[3:0]));
    check(tag, "R1 lanes", {lane_en, lane_thread, lane_slice}, lanes_of(e[3:0], e[6:5]));
    if (eb) void'(q.pop_front());
    start = s; mask_in = m; op_in = o;
    if (s && !eb && rst_n) build(m, o);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 4'd0, 2'd0, tag);
  endtask

  initial begin
    idle(3, "R2");
    rst_n = 1'b1;
    idle(2, "R2");
    step(1'b1, 4'b1011, 2'd0, "R3"); idle(3, "R3");
    step(1'b1, 4'b0111, 2'd1, "R4"); idle(3, "R4");
    step(1'b1, 4'b0011, 2'd1, "R4"); idle(3, "R4");
    step(1'b1, 4'b1111, 2'd1, "R4"); idle(3, "R4");
    step(1'b1, 4'b1010, 2'd1, "R4"); idle(2, "R4");
    step(1'b1, 4'b1101, 2'd2, "R5"); idle(4, "R5");
    step(1'b1, 4'b0101, 2'd3, "R6"); idle(8, "R6");
    step(1'b1, 4'b1111, 2'd3, "R6"); idle(14, "R6");
    for (int o = 0; o < 4; o++) begin
      step(1'b1, 4'd0, 2'(o), "R7"); idle(2, "R7");
    end
    step(1'b1, 4'b1000, 2'd2, "R7"); idle(2, "R7");
    step(1'b1, 4'b0100, 2'd1, "R7"); idle(2, "R7");
    step(1'b1, 4'b1111, 2'd2, "R8");
    for (int i = 0; i < 6; i++) step(1'b1, 4'b0001, 2'd0, "R8");
    idle(3, "R8");
    step(1'b1, 4'b0110, 2'd3, "R8");
    for (int i = 0; i < 4; i++) step(1'b1, 4'b1111, 2'd0, "R8");
    idle(10, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20000 * 5);
    errors++;
    $display("FAIL watchdog R2: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule